// File: doc/BRIEF.md
# SAR Converter Serial Port Model

This block is a synthesizable stand-in for the digital face of a 12-bit successive-approximation converter with a three-wire serial output. A host drives a convert-start line and a serial clock, and reads a tri-statable data line, exactly as it would with the real converter. The analog result is replaced by a parallel sample word, which is captured at the moment the conversion starts.

Convert-start and the serial clock are oversampled by a fast system clock through two-flop synchronizers and edge detectors; nothing runs on the external clock. The block counts serial-clock rising edges within each conversion and shifts out a 16-bit frame. It decides when the data line is driven or released. It also infers power-mode requests from the point in the count at which convert-start goes high again: a normal mode, a partial power-down and a full power-down. A sticky flag marks that the first complete conversion since reset, which stands for the start-up calibration cycle, has taken place.

Top module: `sar_port_model`

## Requirements
- R1: A falling edge on `cnv_i` places the block in hold (`hold_o`=1), captures `sample_i` and drives the data line (`sdo_oe_o`=1) low (`sdo_o`=0).
- R2: After serial-clock rising edge k of a conversion, `sdo_o` is 0 for k=1..3, carries code bit 15-k for k=4..15 (MSB at k=4, LSB at k=15), and is 0 for k=16.
- R3: `hold_o` is 0 after reset and returns to 0 (tracking) on the 14th serial-clock rising edge of a conversion.
- R4: If `cnv_i` rises once 14 or more rising edges have been counted, `sdo_oe_o` stays 1 and `pwr_mode_o` is 0 (normal), so that conversions can run back to back.
- R5: If `cnv_i` is low at the 16th serial-clock falling edge, `sdo_oe_o` stays 1 until the next rising edge of either `cnv_i` or the serial clock, and then goes to 0.
- R6: If `cnv_i` rises after 3 to 13 rising edges while in normal mode, `pwr_mode_o` becomes 1 (partial power-down) and `sdo_oe_o` goes to 0 at once.
- R7: The same sequence while in partial power-down sets `pwr_mode_o` to 2 (full power-down); full power-down is entered from partial power-down only, and the same sequence in full power-down leaves it there.
- R8: A power-down mode is left (`pwr_mode_o` back to 0) only by a conversion in which `cnv_i` rises after at least 14 rising edges.
- R9: With `bipolar_i`=0 the code is `sample_i` unchanged (straight binary); with `bipolar_i`=1 it is `sample_i` with its MSB inverted (two's complement about mid-scale).
- R10: If `cnv_i` rises after fewer than 3 rising edges, the conversion is abandoned: `sdo_oe_o`=0, `hold_o`=0, mode unchanged.
- R11: `calib_done_o` is 0 after reset, becomes 1 on the 16th rising edge of the first conversion and then stays 1.
- R12: After reset `sdo_oe_o`=0 and `pwr_mode_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cnv_i | input | 1 | Convert-start strobe, active falling edge |
| sck_i | input | 1 | Serial clock from the host |
| sample_i | input | DATA_W | Sample word standing for the analog result |
| bipolar_i | input | 1 | 1 selects two's-complement coding |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Serial data drive enable |
| hold_o | output | 1 | 1 in hold, 0 while tracking |
| pwr_mode_o | output | 2 | 0 normal, 1 partial, 2 full power-down |
| calib_done_o | output | 1 | Sticky first-conversion flag |

## Verification
The bench aims at the edges of the power-down window: a rise after exactly 3 edges or 13 edges, and a rise after 14. A design that confused these would either drop into power-down during a continuous run or keep the line driven when sleep was requested. It holds convert-start low across the 16th falling edge and checks that release waits for the next edge of either line; a design that released at the falling edge, or never, would be caught. It also walks normal, partial and full power-down and checks that too short a wake-up leaves full power-down in place, and it checks the MSB inversion at mid-scale and at both ends of the range.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'd0,
        PM_PARTIAL = 2'd1,
        PM_FULL    = 2'd2
    } pwr_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    // Next deeper sleep level for a request in the entry window.
    function automatic pwr_mode_e deeper_mode(input pwr_mode_e m);
        return (m == PM_NORMAL) ? PM_PARTIAL : PM_FULL;
    endfunction

endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pin,
    output sar_port_pkg::edge_ev_t ev
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= {(STAGES+1){RST_VAL}};
        else     pipe <= {pipe[STAGES-1:0], pin};
    end

    always_comb begin
        ev.rise = pipe[STAGES-1] & ~pipe[STAGES];
        ev.fall = ~pipe[STAGES-1] & pipe[STAGES];
    end
endmodule

// File: rtl/sar_frame_shift.sv
module sar_frame_shift #(
    parameter int unsigned DATA_W     = 12,
    parameter int unsigned LEAD_ZEROS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] code,
    output logic              sdo
);
    localparam int unsigned FRAME_LEN = LEAD_ZEROS + DATA_W + 1;

    logic [FRAME_LEN-1:0] word;

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            sdo  <= 1'b0;
        end else if (load) begin
            word <= {{LEAD_ZEROS{1'b0}}, code, 1'b0};
            sdo  <= 1'b0;
        end else if (shift) begin
            sdo  <= word[FRAME_LEN-1];
            word <= {word[FRAME_LEN-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sar_port_model.sv
module sar_port_model #(
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned LEAD_ZEROS  = 3,
    parameter int unsigned TRACK_EDGE  = 14,
    parameter int unsigned PD_MIN_EDGE = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnv_i,
    input  logic              sck_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              bipolar_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              hold_o,
    output logic [1:0]        pwr_mode_o,
    output logic              calib_done_o
);
    import sar_port_pkg::*;

    localparam int unsigned FRAME_LEN = LEAD_ZEROS + DATA_W + 1;
    localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] TRACK_C = CNT_W'(TRACK_EDGE);
    localparam logic [CNT_W-1:0] PDMIN_C = CNT_W'(PD_MIN_EDGE);

    edge_ev_t cnv_ev, sck_ev;
    logic     cnv_fall, cnv_rise;

    sar_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cnv_sync (
        .clk(clk), .rst(rst), .pin(cnv_i), .ev(cnv_ev)
    );
    sar_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst(rst), .pin(sck_i), .ev(sck_ev)
    );

    assign cnv_fall = cnv_ev.fall;
    assign cnv_rise = cnv_ev.rise;

    logic [CNT_W-1:0]  cnt, cnt_inc;
    logic              active, rel_pend, cnv_low, oe_q, hold_q, calib_q;
    pwr_mode_e         mode_q;
    logic [DATA_W-1:0] code;
    logic              shift_en;

    // Straight binary or two's complement about mid-scale.
    assign code     = bipolar_i ? {~sample_i[DATA_W-1], sample_i[DATA_W-2:0]} : sample_i;
    assign cnt_inc  = (cnt == LAST_C) ? cnt : cnt + 1'b1;
    assign shift_en = active & ~rel_pend & sck_ev.rise & ~cnv_fall;

    sar_frame_shift #(.DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS)) u_shift (
        .clk(clk), .rst(rst), .load(cnv_fall), .shift(shift_en),
        .code(code), .sdo(sdo_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            active   <= 1'b0;
            rel_pend <= 1'b0;
            cnv_low  <= 1'b0;
            oe_q     <= 1'b0;
            hold_q   <= 1'b0;
            calib_q  <= 1'b0;
            mode_q   <= PM_NORMAL;
        end else if (cnv_fall) begin
            cnt      <= '0;
            active   <= 1'b1;
            rel_pend <= 1'b0;
            cnv_low  <= 1'b1;
            oe_q     <= 1'b1;
            hold_q   <= 1'b1;
        end else if (cnv_rise) begin
            cnv_low <= 1'b0;
            if (active) begin
                if (cnt >= TRACK_C) begin
                    // late rise: wake up, keep driving unless release is armed
                    mode_q <= PM_NORMAL;
                    if (rel_pend) begin
                        oe_q     <= 1'b0;
                        rel_pend <= 1'b0;
                        active   <= 1'b0;
                    end
                end else begin
                    if (cnt >= PDMIN_C) mode_q <= deeper_mode(mode_q);
                    oe_q   <= 1'b0;
                    hold_q <= 1'b0;
                    active <= 1'b0;
                end
            end
        end else if (active) begin
            if (sck_ev.rise) begin
                if (rel_pend) begin
                    oe_q     <= 1'b0;
                    rel_pend <= 1'b0;
                    active   <= 1'b0;
                end else begin
                    cnt <= cnt_inc;
                    if (cnt_inc == TRACK_C) hold_q  <= 1'b0;
                    if (cnt_inc == LAST_C)  calib_q <= 1'b1;
                end
            end else if (sck_ev.fall && cnt == LAST_C && cnv_low) begin
                rel_pend <= 1'b1;
            end
        end
    end

    assign sdo_oe_o     = oe_q;
    assign hold_o       = hold_q;
    assign pwr_mode_o   = mode_q;
    assign calib_done_o = calib_q;
endmodule

// File: rtl/sar_port_model_chk.sv
module sar_port_model_chk (
    input logic       clk,
    input logic       rst,
    input logic       cnv_fall,
    input logic       cnv_rise,
    input logic       sdo,
    input logic       sdo_oe,
    input logic       hold,
    input logic [1:0] mode,
    input logic       calib
);
    // R1
    oe_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> $past(cnv_fall));

    // R1
    hold_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hold) |-> (sdo_oe && !sdo));

    // R7
    full_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && $past(mode) != 2'd2) |-> $past(mode) == 2'd1);

    // R8
    mode_change_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != $past(mode)) |-> $past(cnv_rise));

    // R6
    sleep_release_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && $past(mode) == 2'd0) |-> !sdo_oe);

    // R11
    calib_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(calib) |-> calib);
endmodule

bind sar_port_model sar_port_model_chk u_chk (
    .clk(clk), .rst(rst), .cnv_fall(cnv_fall), .cnv_rise(cnv_rise),
    .sdo(sdo_o), .sdo_oe(sdo_oe_o), .hold(hold_o), .mode(pwr_mode_o),
    .calib(calib_done_o)
);

// File: tb/sar_port_model_bench.sv
module sar_port_model_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnv = 1'b1;
    logic        sck = 1'b0;
    logic [11:0] sample = '0;
    logic        bip = 1'b0;
    logic        sdo, sdo_oe, hold, calib;
    logic [1:0]  mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sar_port_model u_sar_port_model (
        .clk(clk), .rst(rst), .cnv_i(cnv), .sck_i(sck), .sample_i(sample),
        .bipolar_i(bip), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .hold_o(hold),
        .pwr_mode_o(mode), .calib_done_o(calib)
    );

    // sample[24:13], bipolar[12], expected code[11:0]
    localparam logic [24:0] VEC [6] = '{
        {12'hA5C, 1'b0, 12'hA5C},
        {12'h000, 1'b1, 12'h800},
        {12'hFFF, 1'b1, 12'h7FF},
        {12'h800, 1'b1, 12'h000},
        {12'h001, 1'b0, 12'h001},
        {12'h3C7, 1'b1, 12'hBC7}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic set_cnv(input logic v);
        @(negedge clk); cnv = v; settle();
    endtask

    task automatic sck_rise();
        @(negedge clk); sck = 1'b1; settle();
    endtask

    task automatic sck_fall();
        @(negedge clk); sck = 1'b0; settle();
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sck_rise();
            sck_fall();
        end
    endtask

    function automatic logic exp_bit(input logic [11:0] c, input int k);
        if (k <= 3 || k >= 16) return 1'b0;
        return c[15-k];
    endfunction

    // Continuous frame: convert-start returns high after rising edge 15.
    task automatic run_frame(input logic [11:0] s, input logic b, input logic [11:0] c, input bit first);
        sample = s; bip = b;
        set_cnv(1'b0);
        check(sdo_oe && !sdo && hold, "R1 start", {sdo_oe, sdo, hold}, 3'b101);
        for (int k = 1; k <= 16; k++) begin
            sck_rise();
            check(sdo == exp_bit(c, k), "R2/R9 frame bit", sdo, exp_bit(c, k));
            if (k == 13) check(hold == 1'b1, "R3 hold before 14", hold, 1);
            if (k == 14) check(hold == 1'b0, "R3 track at 14", hold, 0);
            if (k == 15) begin
                if (first) check(calib == 1'b0, "R11 calib before end", calib, 0);
                set_cnv(1'b1);
                check(sdo_oe == 1'b1, "R4 stays driven", sdo_oe, 1);
                check(mode == 2'd0, "R4 mode normal", mode, 0);
            end
            if (k == 16 && first) check(calib == 1'b1, "R11 calib set", calib, 1);
            sck_fall();
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        settle();
        // R12 / R3 / R11 reset state
        check(sdo_oe == 1'b0, "R12 oe reset", sdo_oe, 0);
        check(mode == 2'd0, "R12 mode reset", mode, 0);
        check(hold == 1'b0, "R3 tracking after reset", hold, 0);
        check(calib == 1'b0, "R11 calib reset", calib, 0);

        foreach (VEC[i])
            run_frame(VEC[i][24:13], VEC[i][12], VEC[i][11:0], i == 0);
        check(calib == 1'b1, "R11 calib sticky", calib, 1);

        // R5: release on next serial-clock rising edge
        set_cnv(1'b0);
        pulses(16);
        check(sdo_oe == 1'b1, "R5 held after 16th fall", sdo_oe, 1);
        sck_rise();
        check(sdo_oe == 1'b0, "R5 released by sck", sdo_oe, 0);
        sck_fall();
        set_cnv(1'b1);
        check(sdo_oe == 1'b0 && mode == 2'd0, "R5 idle normal", {sdo_oe, mode}, 0);

        // R5: release on convert-start rising edge
        set_cnv(1'b0);
        pulses(16);
        check(sdo_oe == 1'b1, "R5 held before cnv rise", sdo_oe, 1);
        set_cnv(1'b1);
        check(sdo_oe == 1'b0, "R5 released by cnv", sdo_oe, 0);

        // R10: abandon after 2 edges
        set_cnv(1'b0);
        pulses(2);
        set_cnv(1'b1);
        check(sdo_oe == 1'b0 && hold == 1'b0, "R10 abandon", {sdo_oe, hold}, 0);
        check(mode == 2'd0, "R10 mode kept", mode, 0);

        // R6: partial after exactly 3 edges
        set_cnv(1'b0);
        pulses(3);
        check(sdo_oe == 1'b1, "R6 driven before rise", sdo_oe, 1);
        set_cnv(1'b1);
        check(mode == 2'd1, "R6 partial", mode, 1);
        check(sdo_oe == 1'b0, "R6 released", sdo_oe, 0);

        // R7: full after 13 edges from partial
        set_cnv(1'b0);
        pulses(13);
        set_cnv(1'b1);
        check(mode == 2'd2, "R7 full", mode, 2);

        // R7/R8: 10 edges in full stays full
        set_cnv(1'b0);
        pulses(10);
        set_cnv(1'b1);
        check(mode == 2'd2, "R8 short wake stays full", mode, 2);

        // R8: 14 edges wakes up
        set_cnv(1'b0);
        pulses(14);
        set_cnv(1'b1);
        check(mode == 2'd0, "R8 wake from full", mode, 0);
        check(sdo_oe == 1'b1, "R8 driven after wake", sdo_oe, 1);
        pulses(2);

        // R6 then R8 from partial
        set_cnv(1'b0);
        pulses(8);
        set_cnv(1'b1);
        check(mode == 2'd1, "R6 partial again", mode, 1);
        set_cnv(1'b0);
        pulses(15);
        set_cnv(1'b1);
        check(mode == 2'd0, "R8 wake from partial", mode, 0);
        pulses(1);

        // R9 after sleep: frame still coded
        run_frame(12'h123, 1'b1, 12'h923, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule